// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Parity

This block sends and receives asynchronous serial characters at the same time. A character holds 7, 8 or 9 data bits and may carry an even or odd parity bit. Each direction has a single holding buffer. The transmit side takes a data byte plus a ninth bit through a write strobe. The receive side presents the last character, including its ninth bit, and a full flag that a status-read strobe clears.

One oversample tick drives both directions. The tick comes either from a divided system clock or from an external timer pulse, and there are sixteen ticks to a bit. The receiver confirms a start bit at its midpoint. It samples every later bit at mid-bit and keeps three sticky error flags: parity, overrun and framing. Software clears each of these flags separately. An inversion control flips the polarity of both the outgoing and the incoming line.

Top module: `uart_core`

## Requirements
- R1: `mode` selects the character length: 2'b00 gives 7 data bits, 2'b01 gives 8 and 2'b10 gives 9. The ninth transmitted bit is `tx_bit8` and the ninth received bit appears on `rx_bit8`. In 7-bit mode `rx_data[7]` reads 0, and outside 9-bit mode `rx_bit8` reads 0.
- R2: `mode` = 2'b11 is reserved. A pending character is not sent while that code is set, and it goes out once a valid code is selected.
- R3: `rate_sel` codes 0 to 5 give one oversample tick every 13·2^code clocks, and code 7 gives one every 96 clocks (all multiplied by SCALE). Code 6 uses each `ext_tick` pulse as the tick. A bit lasts 16 ticks.
- R4: The line idles high. A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then one high stop bit.
- R5: With `par_en` = 1, a parity bit follows the data. When `par_even` = 1 the data bits plus the parity bit hold an even number of ones; when `par_even` = 0 they hold an odd number.
- R6: `tx_empty` is 1 after reset. It drops on a `tx_wr` and on the rising edge of `tx_en`. It rises when the buffered character moves into the shifter. Nothing is sent until a write has been made.
- R7: `rx_full` rises when a character completes. It drops on `stat_rd` and on the rising edge of `rx_en`.
- R8: The receiver rejects a low pulse that has ended by the midpoint of the start bit. A stop bit sampled low sets `err_frame`, and the receiver then waits for the line to return high. A received parity bit that does not match sets `err_parity`.
- R9: If a character completes while `rx_full` is 1 and `stat_rd` is low, `err_overrun` sets and `rx_data`/`rx_bit8` keep the older character. If `stat_rd` is high in the completion cycle, the new character loads and no overrun is flagged.
- R10: The error flags hold until their bit of `err_clr` is pulsed: bit 0 clears framing, bit 1 clears overrun and bit 2 clears parity. A new error in the same cycle as its clear wins.
- R11: `inv_en` = 1 inverts both `txd` and the incoming `rxd`, so the idle `txd` level becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Character length code |
| rate_sel | input | 3 | Oversample tick source and divisor |
| ext_tick | input | 1 | External timer pulse used by rate code 6 |
| par_en | input | 1 | Add and check a parity bit |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| inv_en | input | 1 | Invert the TX and RX lines |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Transmit data byte |
| tx_bit8 | input | 1 | Ninth transmit bit |
| stat_rd | input | 1 | Status read strobe, clears rx_full |
| err_clr | input | 3 | Per-flag error clear (0 frame, 1 overrun, 2 parity) |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive buffer full flag |
| rx_data | output | 8 | Received data byte |
| rx_bit8 | output | 1 | Ninth received bit |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_frame | output | 1 | Sticky framing error |

## Verification
The case to watch is a status read that falls in the same cycle as a receive completion while the buffer still holds an unread character. The bench drives the frames itself against a tick that it generates, so every cycle is fixed. It first times a calibration frame to find the cycle in which `rx_full` rises. It then leaves one character unread and pulses `stat_rd` exactly one cycle before the completion of the next frame. The result is judged at the ports: the new byte must be in `rx_data`, `rx_full` must still be 1 and `err_overrun` must stay 0. Any other outcome shows that the design gave priority to the overrun or to the clear.

// File: rtl/uart_pkg.sv
package uart_pkg;

  localparam int FRAME_W = 12;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT
  } rx_state_e;

  function automatic logic [3:0] data_bits(input logic [1:0] m);
    case (m)
      2'b00:   return 4'd7;
      2'b01:   return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic [8:0] mask_data(input logic [8:0] d, input logic [1:0] m);
    case (m)
      2'b00:   return {2'b00, d[6:0]};
      2'b01:   return {1'b0, d[7:0]};
      default: return d;
    endcase
  endfunction

  // parity bit that makes the ones count even (ev=1) or odd (ev=0)
  function automatic logic par_calc(input logic [8:0] d, input logic ev);
    return ev ? (^d) : ~(^d);
  endfunction

  function automatic logic [15:0] rate_div(input logic [2:0] sel, input int scale);
    int base;
    if (sel == 3'd7) base = 96;
    else             base = 13 << sel;
    return 16'(base * scale);
  endfunction

  function automatic logic [FRAME_W-1:0] frame_bits(input logic [8:0] d, input logic [1:0] m,
                                                     input logic pe, input logic ev);
    logic [FRAME_W-1:0] f;
    logic [8:0] dm;
    logic [3:0] nb;
    nb = data_bits(m);
    dm = mask_data(d, m);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (4'(i) < nb) f[i+1] = dm[i];
    end
    if (pe) f[nb+4'd1] = par_calc(dm, ev);
    return f;
  endfunction

  function automatic logic [3:0] frame_len(input logic [1:0] m, input logic pe);
    return data_bits(m) + 4'd2 + {3'b000, pe};
  endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int SCALE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       ext_tick,
  output logic       os_tick
);
  import uart_pkg::*;

  localparam int CW = 16;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = rate_div(rate_sel, SCALE) - 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign os_tick = (rate_sel == 3'd6) ? ext_tick : (cnt == lim);

  // R3: an internally divided tick never lasts two cycles
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && rate_sel != 3'd6 && $stable(rate_sel)) |=> !os_tick);

endmodule

// File: rtl/uart_tx.sv
module uart_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       pend,
  input  logic [8:0] data9,
  output logic       take,
  output logic       busy,
  output logic       line
);
  import uart_pkg::*;

  logic [FRAME_W-1:0] sh;
  logic [3:0]         left;
  logic [3:0]         tcnt;

  assign take = pend && en && !busy && (mode != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
      busy <= 1'b0;
    end else if (take) begin
      sh   <= frame_bits(data9, mode, par_en, par_even);
      left <= frame_len(mode, par_en);
      tcnt <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == 4'd15) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 1'b1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign line = busy ? sh[0] : 1'b1;

  // R2: with the reserved length code an idle shifter stays idle
  a_r2_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !busy) |=> !busy);

endmodule

// File: rtl/uart_rx.sv
module uart_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       ln,
  output logic       done,
  output logic [8:0] data9,
  output logic       perr,
  output logic       ferr
);
  import uart_pkg::*;

  rx_state_e  st;
  logic [3:0] cnt;
  logic [3:0] idx;
  logic [8:0] sh;
  logic       pbit;
  logic [3:0] nb;
  logic [8:0] got;

  assign nb = data_bits(mode);

  always_comb begin
    case (mode)
      2'b00:   got = {2'b00, sh[8:2]};
      2'b01:   got = {1'b0, sh[8:1]};
      default: got = sh;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0; pbit <= 1'b0;
      done <= 1'b0; data9 <= '0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en || mode == 2'b11) begin
        st <= RX_IDLE;
      end else begin
        case (st)
          RX_IDLE: if (!ln) begin st <= RX_START; cnt <= '0; end
          RX_START: if (tick) begin
            if (cnt == 4'd7) begin
              cnt <= '0; idx <= '0;
              st  <= ln ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: if (tick) begin
            if (cnt == 4'd15) begin
              cnt <= '0;
              sh  <= {ln, sh[8:1]};
              idx <= idx + 1'b1;
              if (idx == nb - 4'd1) st <= par_en ? RX_PAR : RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_PAR: if (tick) begin
            if (cnt == 4'd15) begin
              cnt <= '0; pbit <= ln; st <= RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: if (tick) begin
            if (cnt == 4'd15) begin
              cnt   <= '0;
              done  <= 1'b1;
              data9 <= got;
              ferr  <= !ln;
              perr  <= par_en && (pbit != par_calc(got, par_even));
              st    <= ln ? RX_IDLE : RX_WAIT;
            end else cnt <= cnt + 1'b1;
          end
          RX_WAIT: if (ln) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R8: a completion is reported in one cycle only
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/uart_core.sv
module uart_core #(
  parameter int SCALE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [2:0] rate_sel,
  input  logic       ext_tick,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       inv_en,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_bit8,
  input  logic       stat_rd,
  input  logic [2:0] err_clr,
  output logic       txd,
  input  logic       rxd,
  output logic       tx_empty,
  output logic       rx_full,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_frame
);

  logic       os_tick;
  logic [8:0] tx_buf;
  logic       tx_pend, tx_take, tx_busy, tx_line;
  logic       tx_en_q, rx_en_q;
  logic       rx_meta, rx_sync;
  logic       rx_done, rx_perr, rx_ferr;
  logic [8:0] rx_word, rx_buf;

  uart_baud #(.SCALE(SCALE)) u_baud (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_tick(ext_tick), .os_tick(os_tick)
  );

  uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(tx_en), .mode(mode),
    .par_en(par_en), .par_even(par_even), .pend(tx_pend), .data9(tx_buf),
    .take(tx_take), .busy(tx_busy), .line(tx_line)
  );

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(rx_en), .mode(mode),
    .par_en(par_en), .par_even(par_even), .ln(rx_sync ^ inv_en),
    .done(rx_done), .data9(rx_word), .perr(rx_perr), .ferr(rx_ferr)
  );

  assign txd = tx_line ^ inv_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0; tx_pend <= 1'b0; tx_empty <= 1'b1;
      tx_en_q <= 1'b0; rx_en_q <= 1'b0;
      rx_meta <= 1'b1; rx_sync <= 1'b1;
    end else begin
      tx_en_q <= tx_en;
      rx_en_q <= rx_en;
      rx_meta <= rxd;
      rx_sync <= rx_meta;
      if (tx_wr) begin
        tx_buf   <= {tx_bit8, tx_data};
        tx_pend  <= 1'b1;
        tx_empty <= 1'b0;
      end else if (tx_take) begin
        tx_pend  <= 1'b0;
        tx_empty <= 1'b1;
      end else if (tx_en && !tx_en_q) begin
        tx_empty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0; rx_full <= 1'b0;
      err_parity <= 1'b0; err_overrun <= 1'b0; err_frame <= 1'b0;
    end else begin
      if (rx_done) begin
        if (!rx_full || stat_rd) begin
          rx_buf  <= rx_word;
          rx_full <= 1'b1;
        end
      end else if (stat_rd || (rx_en && !rx_en_q)) begin
        rx_full <= 1'b0;
      end
      if (rx_done && rx_ferr)                     err_frame <= 1'b1;
      else if (err_clr[0])                        err_frame <= 1'b0;
      if (rx_done && rx_full && !stat_rd)         err_overrun <= 1'b1;
      else if (err_clr[1])                        err_overrun <= 1'b0;
      if (rx_done && rx_perr)                     err_parity <= 1'b1;
      else if (err_clr[2])                        err_parity <= 1'b0;
    end
  end

  assign rx_data = rx_buf[7:0];
  assign rx_bit8 = rx_buf[8];

  // R6: a write always leaves the buffer marked occupied
  a_r6_wr_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty);

  // R7: a read with no completion empties the receive buffer
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_done) |=> !rx_full);

  // R9: an unread buffer survives a new completion
  a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !stat_rd) |=> (err_overrun && rx_full && $stable(rx_buf)));

  // R10: error flags only drop on their clear bit
  a_r10_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !err_clr[0]) |=> err_frame);
  a_r10_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !err_clr[2]) |=> err_parity);

endmodule

// File: tb/sim_uart_core.sv
module sim_uart_core;

  localparam int BP0 = 208;
  localparam int EXT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [2:0] rate_sel = 3'd0;
  logic       ext_tick;
  logic       par_en = 1'b0, par_even = 1'b0, inv_en = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0, tx_wr = 1'b0, tx_bit8 = 1'b0;
  logic [7:0] tx_data = '0;
  logic       stat_rd;
  logic [2:0] err_clr = '0;
  logic       txd, rxd;
  logic       tx_empty, rx_full, rx_bit8, err_parity, err_overrun, err_frame;
  logic [7:0] rx_data;

  logic       lb = 1'b1, drv = 1'b1;
  logic       mon_en = 1'b1, mon_rd = 1'b0, man_rd = 1'b0;
  int         ecnt = 0;
  int         n_chk = 0, n_fail = 0;
  int         full_at = 0;
  bit         fin = 1'b0;
  logic [8:0] exp_q[$];

  always #4 clk = ~clk;

  always @(posedge clk) ecnt <= (ecnt == EXT - 1) ? 0 : ecnt + 1;
  assign ext_tick = (ecnt == 0);
  assign rxd      = lb ? txd : (drv ^ inv_en);
  assign stat_rd  = mon_rd | man_rd;

  uart_core u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate_sel(rate_sel), .ext_tick(ext_tick),
    .par_en(par_en), .par_even(par_even), .inv_en(inv_en), .tx_en(tx_en), .rx_en(rx_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit8(tx_bit8), .stat_rd(stat_rd), .err_clr(err_clr),
    .txd(txd), .rxd(rxd), .tx_empty(tx_empty), .rx_full(rx_full), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .err_parity(err_parity), .err_overrun(err_overrun), .err_frame(err_frame)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // expected parity bit, counted independently of the design
  function automatic logic ref_par(input logic [8:0] d, input int nb, input logic ev);
    int ones = 0;
    for (int i = 0; i < nb; i++) if (d[i]) ones++;
    return ev ? logic'(ones % 2) : logic'(1 - ones % 2);
  endfunction

  // scoreboard monitor: compare each completed character with the queue head
  always @(negedge clk) begin
    if (mon_rd) mon_rd = 1'b0;
    else if (mon_en && rx_full) begin
      if (exp_q.size() == 0) chk("R4 unexpected character", {7'd0, rx_bit8, rx_data}, 16'hFFFF);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R1/R4 received word", {7'd0, rx_bit8, rx_data}, {7'd0, e});
        chk("R5 no error on clean frame", {13'd0, err_parity, err_overrun, err_frame}, 16'd0);
      end
      mon_rd = 1'b1;
    end
  end

  task automatic send(input logic [8:0] d, input logic [8:0] e);
    exp_q.push_back(e);
    @(negedge clk);
    tx_data = d[7:0]; tx_bit8 = d[8]; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 40000) begin @(negedge clk); t++; end
    chk("R4 scoreboard drained", 16'(exp_q.size()), 16'd0);
    repeat (2000) @(negedge clk);
  endtask

  task automatic meas_start(input string req, input int lo, input int hi);
    int t = 0, w = 0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    while (txd === 1'b0 && w < 5000) begin @(negedge clk); w++; end
    chk_rng(req, w, lo, hi);
  endtask

  task automatic rd_pulse();
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
  endtask

  task automatic clr_pulse(input logic [2:0] c);
    @(negedge clk); err_clr = c;
    @(negedge clk); err_clr = 3'b000;
  endtask

  // drive a frame from the bench: start, data LSB first, optional parity, stop
  task automatic raw_frame(input logic [8:0] d, input int nb, input bit pe, input logic pb,
                           input logic stop, input int bp, input bit align, input int rd_at);
    logic [11:0] f;
    int n, cyc = 0;
    bit seen = 1'b0;
    f = '1; f[0] = 1'b0;
    for (int i = 0; i < nb; i++) f[i+1] = d[i];
    if (pe) f[nb+1] = pb;
    n = nb + 2 + (pe ? 1 : 0);
    f[n-1] = stop;
    if (align) while (ecnt != 0) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      drv = f[i];
      repeat (bp) begin
        @(negedge clk);
        cyc++;
        man_rd = (cyc == rd_at);
        if (!seen && rx_full) begin full_at = cyc; seen = 1'b1; end
      end
    end
    man_rd = 1'b0;
    drv = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset tx_empty", {15'd0, tx_empty}, 16'd1);
    chk("R7 reset rx_full", {15'd0, rx_full}, 16'd0);
    chk("R4 reset idle line", {15'd0, txd}, 16'd1);
    chk("R10 reset errors", {13'd0, err_parity, err_overrun, err_frame}, 16'd0);

    tx_en = 1'b1; rx_en = 1'b1;
    @(negedge clk);
    chk("R6 enable clears tx_empty", {15'd0, tx_empty}, 16'd0);
    repeat (BP0) @(negedge clk);
    chk("R6 no send without write", {15'd0, txd}, 16'd1);

    send(9'h0A5, 9'h0A5);
    chk("R6 write clears tx_empty", {15'd0, tx_empty}, 16'd0);
    @(negedge clk);
    chk("R6 handoff sets tx_empty", {15'd0, tx_empty}, 16'd1);
    drain();
    send(9'h13C, 9'h03C); drain();

    mode = 2'b00;                                   // R1 7-bit
    send(9'h1FF, 9'h07F); drain();
    mode = 2'b10; par_en = 1'b1; par_even = 1'b1;   // R1 9-bit, R5 even
    send(9'h1A3, 9'h1A3); drain();
    send(9'h0FF, 9'h0FF); drain();
    mode = 2'b01; par_even = 1'b0;                  // R5 odd
    send(9'h055, 9'h055); drain();
    par_en = 1'b0;

    inv_en = 1'b1;                                  // R11
    repeat (4) @(negedge clk);
    chk("R11 inverted idle level", {15'd0, txd}, 16'd0);
    send(9'h0C3, 9'h0C3); drain();
    inv_en = 1'b0;
    repeat (4) @(negedge clk);

    rate_sel = 3'd1;                                // R3 divisor 26
    send(9'h055, 9'h055); meas_start("R3 start bit rate 1", 416 - 26, 418); drain();
    rate_sel = 3'd7;
    send(9'h055, 9'h055); meas_start("R3 start bit rate 7", 1536 - 96, 1538); drain();
    rate_sel = 3'd6;
    send(9'h055, 9'h055); meas_start("R3 start bit ext tick", 16 * EXT - EXT, 16 * EXT + 2); drain();
    rate_sel = 3'd0;

    mode = 2'b11;                                   // R2 reserved
    exp_q.push_back(9'h0F0);
    @(negedge clk); tx_data = 8'hF0; tx_bit8 = 1'b0; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    begin
      int lows = 0;
      repeat (3 * BP0) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk("R2 reserved code sends nothing", 16'(lows), 16'd0);
      chk("R2 buffer still pending", {15'd0, tx_empty}, 16'd0);
    end
    mode = 2'b01;
    drain();

    mon_en = 1'b0; lb = 1'b0;
    repeat (10) @(negedge clk);
    par_en = 1'b1; par_even = 1'b1;
    raw_frame(9'h00F, 8, 1'b1, ~ref_par(9'h00F, 8, 1'b1), 1'b1, BP0, 1'b0, -1);
    chk("R8 parity error data", {8'd0, rx_data}, 16'h000F);
    chk("R8 parity error flag", {14'd0, err_parity, err_frame}, 16'b10);
    rd_pulse();
    chk("R7 read clears rx_full", {15'd0, rx_full}, 16'd0);
    chk("R10 parity flag survives read", {15'd0, err_parity}, 16'd1);
    clr_pulse(3'b100);
    chk("R10 parity flag cleared", {15'd0, err_parity}, 16'd0);

    par_en = 1'b0;
    raw_frame(9'h081, 8, 1'b0, 1'b0, 1'b0, BP0, 1'b0, -1);
    chk("R8 framing error flag", {15'd0, err_frame}, 16'd1);
    chk("R8 framing frame data", {8'd0, rx_data}, 16'h0081);
    rd_pulse();
    clr_pulse(3'b001);
    chk("R10 framing flag cleared", {15'd0, err_frame}, 16'd0);
    repeat (2 * BP0) @(negedge clk);
    chk("R8 no frame after low stop", {15'd0, rx_full}, 16'd0);

    drv = 1'b0; repeat (50) @(negedge clk); drv = 1'b1;
    repeat (2 * BP0) @(negedge clk);
    chk("R8 short glitch rejected", {15'd0, rx_full}, 16'd0);

    raw_frame(9'h011, 8, 1'b0, 1'b0, 1'b1, BP0, 1'b0, -1);
    raw_frame(9'h022, 8, 1'b0, 1'b0, 1'b1, BP0, 1'b0, -1);
    chk("R9 overrun flag", {15'd0, err_overrun}, 16'd1);
    chk("R9 old data kept", {8'd0, rx_data}, 16'h0011);
    rd_pulse();
    clr_pulse(3'b010);
    chk("R10 overrun flag cleared", {15'd0, err_overrun}, 16'd0);

    rate_sel = 3'd6;
    repeat (10) @(negedge clk);
    raw_frame(9'h05A, 8, 1'b0, 1'b0, 1'b1, 16 * EXT, 1'b1, -1);
    chk("R9 calibration frame", {8'd0, rx_data}, 16'h005A);
    rd_pulse();
    raw_frame(9'h033, 8, 1'b0, 1'b0, 1'b1, 16 * EXT, 1'b1, -1);
    raw_frame(9'h044, 8, 1'b0, 1'b0, 1'b1, 16 * EXT, 1'b1, full_at - 1);
    chk("R9 read with completion loads new", {8'd0, rx_data}, 16'h0044);
    chk("R9 read with completion no overrun", {15'd0, err_overrun}, 16'd0);
    chk("R9 buffer full after same-cycle read", {15'd0, rx_full}, 16'd1);

    rx_en = 1'b0; repeat (3) @(negedge clk);
    rx_en = 1'b1; repeat (2) @(negedge clk);
    chk("R7 receive enable clears rx_full", {15'd0, rx_full}, 16'd0);

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule